// File: doc/BRIEF.md
# Pairable Eight-Channel Pulse-Width Modulator

This block generates up to eight independent pulse-width modulated outputs. Each channel has its own period, duty and polarity settings, an eight-bit up-counter, and an external clock-enable tick. A tick advances the channel by one step. Prescaling and clock selection happen outside the block. Software programs the channels through a byte-wide register port: a write strobe, an address, write data, and read data that is decoded combinationally from the address.

Two neighbouring channels (0 with 1, 2 with 3, 4 with 5, 6 with 7) can be joined into one sixteen-bit channel when a wider period or finer duty resolution is needed. In that mode:
- the odd channel's enable, polarity and tick drive the joined counter;
- the waveform appears on the odd line;
- the even line stays low.

A channel that has just been enabled stays quiet until its tick arrives. The first tick opens a fresh period at count zero. Period and duty values are captured only at period boundaries, so a rewrite never produces a runt pulse.

Top module: `pairable_pwm`

## Requirements
- R1: Bit n of the enable register controls channel n. While a channel is disabled, its counter reads 0 and its output is low, starting from the cycle after the enable bit clears.
- R2: After an enable bit is set, the output stays low and the counter stays at 0 until that channel's first tick. That tick starts a period at count 0.
- R3: A running channel adds one to its counter on each tick. After reaching period minus 1, the counter returns to 0. A period of 0 or 1 keeps the counter at 0.
- R4: With polarity bit 1, the output is high while count < duty and low otherwise. With polarity bit 0, the output is low while count < duty and high otherwise.
- R5: If duty ≥ period, the output stays at its starting level for the whole period. If duty is 0, the output stays at the opposite level.
- R6: Period and duty writes are captured only when a period starts (the first tick after enable, or a wrap). Without a tick or a register write, no output changes.
- R7: Join bit k (address 0x02, bit k) joins channels 2k and 2k+1 into one 16-bit channel. The even channel's period, duty and counter form the high byte and the odd channel's form the low byte. The odd channel's enable, polarity and tick control the joined channel, and its waveform appears on output 2k+1.
- R8: While a pair is joined, output 2k is low, and the even channel's enable bit and tick have no effect.
- R9: Changing a join bit stops both channels of the pair and clears their counters one cycle after the write. Each controlling channel then restarts on its next tick.
- R10: Writes to unimplemented bits (join bits 7:4) and to unmapped addresses are ignored. Those bits and addresses read back as 0.
- R11: A synchronous reset clears every register, counter and output to 0.
- R12: Address map:

  | Address | Register |
  |---------|----------|
  | 0x00 | enable |
  | 0x01 | polarity (bit n = channel n) |
  | 0x02 | join |
  | 0x08+n | period of channel n |
  | 0x10+n | duty of channel n |
  | 0x18+n | counter of channel n (read-only) |

  Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | NUM_CH | Per-channel clock-enable tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Register read data for `addr` |
| pwm_out | output | NUM_CH | Modulated outputs |

## Verification
A wrong latched period or counter value shows up at `pwm_out` within one period: the affected channel's edge lands on a different tick than the arithmetic model predicts. It also shows up at once in the counter read-back. A wrong run flag or join mode shows up one cycle after the enable or join write, either as a level on a line that must be low or as a first edge that arrives before the first tick. Every tick of each swept configuration is compared, so any error is caught within the cycle after the tick that exposes it.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   // Register addresses; channel-indexed banks add the channel number.
   localparam int ADR_ENABLE   = 0;
   localparam int ADR_POLARITY = 1;
   localparam int ADR_JOIN     = 2;
   localparam int ADR_PERIOD   = 8;
   localparam int ADR_DUTY     = 16;
   localparam int ADR_COUNT    = 24;
   localparam int MAX_CH       = 8;
   localparam int MIN_ADDR_W   = 5;
endpackage

// File: rtl/pwm_step.sv
// Next-state and level logic for one counter lane of width W.
module pwm_step #(
   parameter int W = 8
) (
   input  logic         en,
   input  logic         tick,
   input  logic         run,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] perl,
   input  logic [W-1:0] dtyl,
   input  logic [W-1:0] per_new,
   input  logic [W-1:0] dty_new,
   input  logic         pol,
   output logic         run_n,
   output logic [W-1:0] cnt_n,
   output logic [W-1:0] perl_n,
   output logic [W-1:0] dtyl_n,
   output logic         lvl
);
   logic [W:0] cnt_inc;
   assign cnt_inc = {1'b0, cnt} + (W+1)'(1);

   always_comb begin
      run_n  = run;
      cnt_n  = cnt;
      perl_n = perl;
      dtyl_n = dtyl;
      if (!en) begin
         run_n = 1'b0;
         cnt_n = '0;
      end else if (tick) begin
         if (!run || (cnt_inc >= {1'b0, perl})) begin
            run_n  = 1'b1;
            cnt_n  = '0;
            perl_n = per_new;
            dtyl_n = dty_new;
         end else begin
            cnt_n = cnt_inc[W-1:0];
         end
      end
   end

   assign lvl = run & ((cnt < dtyl) ? pol : ~pol);
endmodule

// File: rtl/pwm_pair.sv
// Two adjacent channels that can run apart or as one double-width channel.
module pwm_pair #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              join_req,
   input  logic              en_e,
   input  logic              en_o,
   input  logic              pol_e,
   input  logic              pol_o,
   input  logic              tick_e,
   input  logic              tick_o,
   input  logic [DATA_W-1:0] per_e,
   input  logic [DATA_W-1:0] per_o,
   input  logic [DATA_W-1:0] dty_e,
   input  logic [DATA_W-1:0] dty_o,
   output logic [DATA_W-1:0] cnt_e,
   output logic [DATA_W-1:0] cnt_o,
   output logic              out_e,
   output logic              out_o
);
   localparam int PW = 2 * DATA_W;

   logic [PW-1:0] cnt_q, perl_q, dtyl_q;
   logic          run_e_q, run_o_q, mode_q;

   logic              w_run, w_lvl;
   logic [PW-1:0]     w_cnt, w_perl, w_dtyl;
   logic              e_run, e_lvl, o_run, o_lvl;
   logic [DATA_W-1:0] e_cnt, e_perl, e_dtyl, o_cnt, o_perl, o_dtyl;

   pwm_step #(.W(PW)) u_wide (
      .en(en_o), .tick(tick_o), .run(run_o_q), .cnt(cnt_q),
      .perl(perl_q), .dtyl(dtyl_q),
      .per_new({per_e, per_o}), .dty_new({dty_e, dty_o}), .pol(pol_o),
      .run_n(w_run), .cnt_n(w_cnt), .perl_n(w_perl), .dtyl_n(w_dtyl),
      .lvl(w_lvl)
   );

   pwm_step #(.W(DATA_W)) u_even (
      .en(en_e), .tick(tick_e), .run(run_e_q), .cnt(cnt_q[PW-1:DATA_W]),
      .perl(perl_q[PW-1:DATA_W]), .dtyl(dtyl_q[PW-1:DATA_W]),
      .per_new(per_e), .dty_new(dty_e), .pol(pol_e),
      .run_n(e_run), .cnt_n(e_cnt), .perl_n(e_perl), .dtyl_n(e_dtyl),
      .lvl(e_lvl)
   );

   pwm_step #(.W(DATA_W)) u_odd (
      .en(en_o), .tick(tick_o), .run(run_o_q), .cnt(cnt_q[DATA_W-1:0]),
      .perl(perl_q[DATA_W-1:0]), .dtyl(dtyl_q[DATA_W-1:0]),
      .per_new(per_o), .dty_new(dty_o), .pol(pol_o),
      .run_n(o_run), .cnt_n(o_cnt), .perl_n(o_perl), .dtyl_n(o_dtyl),
      .lvl(o_lvl)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         perl_q  <= '0;
         dtyl_q  <= '0;
         run_e_q <= 1'b0;
         run_o_q <= 1'b0;
         mode_q  <= 1'b0;
      end else if (join_req != mode_q) begin
         mode_q  <= join_req;
         run_e_q <= 1'b0;
         run_o_q <= 1'b0;
         cnt_q   <= '0;
      end else if (mode_q) begin
         run_e_q <= 1'b0;
         run_o_q <= w_run;
         cnt_q   <= w_cnt;
         perl_q  <= w_perl;
         dtyl_q  <= w_dtyl;
      end else begin
         run_e_q <= e_run;
         run_o_q <= o_run;
         cnt_q   <= {e_cnt, o_cnt};
         perl_q  <= {e_perl, o_perl};
         dtyl_q  <= {e_dtyl, o_dtyl};
      end
   end

   assign cnt_e = cnt_q[PW-1:DATA_W];
   assign cnt_o = cnt_q[DATA_W-1:0];
   assign out_e = ~mode_q & e_lvl;
   assign out_o = mode_q ? w_lvl : o_lvl;
endmodule

// File: rtl/pwm_regs.sv
// Byte-wide register file with combinational read-back.
module pwm_regs #(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 5
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [NUM_CH*DATA_W-1:0] cnt_flat,
   output logic [DATA_W-1:0]        rdata,
   output logic [NUM_CH-1:0]        en_o,
   output logic [NUM_CH-1:0]        pol_o,
   output logic [NUM_CH/2-1:0]      join_o,
   output logic [NUM_CH*DATA_W-1:0] per_flat,
   output logic [NUM_CH*DATA_W-1:0] dty_flat
);
   import pwm_pkg::*;
   localparam int NUM_PAIRS = NUM_CH / 2;

   logic [NUM_CH-1:0]    en_q, pol_q;
   logic [NUM_PAIRS-1:0] join_q;
   logic [DATA_W-1:0]    per_q [NUM_CH];
   logic [DATA_W-1:0]    dty_q [NUM_CH];

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q   <= '0;
         pol_q  <= '0;
         join_q <= '0;
         for (int n = 0; n < NUM_CH; n++) begin
            per_q[n] <= '0;
            dty_q[n] <= '0;
         end
      end else if (wr_en) begin
         if (addr == ADDR_W'(ADR_ENABLE))   en_q   <= wdata[NUM_CH-1:0];
         if (addr == ADDR_W'(ADR_POLARITY)) pol_q  <= wdata[NUM_CH-1:0];
         if (addr == ADDR_W'(ADR_JOIN))     join_q <= wdata[NUM_PAIRS-1:0];
         for (int n = 0; n < NUM_CH; n++) begin
            if (addr == ADDR_W'(ADR_PERIOD + n)) per_q[n] <= wdata;
            if (addr == ADDR_W'(ADR_DUTY + n))   dty_q[n] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(ADR_ENABLE))   rdata[NUM_CH-1:0]    = en_q;
      if (addr == ADDR_W'(ADR_POLARITY)) rdata[NUM_CH-1:0]    = pol_q;
      if (addr == ADDR_W'(ADR_JOIN))     rdata[NUM_PAIRS-1:0] = join_q;
      for (int n = 0; n < NUM_CH; n++) begin
         if (addr == ADDR_W'(ADR_PERIOD + n)) rdata = per_q[n];
         if (addr == ADDR_W'(ADR_DUTY + n))   rdata = dty_q[n];
         if (addr == ADDR_W'(ADR_COUNT + n))  rdata = cnt_flat[n*DATA_W +: DATA_W];
      end
   end

   assign en_o   = en_q;
   assign pol_o  = pol_q;
   assign join_o = join_q;
   for (genvar n = 0; n < NUM_CH; n++) begin : g_flat
      assign per_flat[n*DATA_W +: DATA_W] = per_q[n];
      assign dty_flat[n*DATA_W +: DATA_W] = dty_q[n];
   end
endmodule

// File: rtl/pairable_pwm.sv
module pairable_pwm #(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [NUM_CH-1:0] pwm_out
);
   import pwm_pkg::*;
   localparam int NUM_PAIRS = NUM_CH / 2;

   if (NUM_CH % 2 != 0 || NUM_CH < 2 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("NUM_CH must be even and between 2 and %0d", MAX_CH);
   end
   if (DATA_W < NUM_CH) begin : g_bad_w
      $error("DATA_W must hold one bit per channel");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_a
      $error("ADDR_W must be at least %0d", MIN_ADDR_W);
   end

   logic [NUM_CH-1:0]        en_w, pol_w;
   logic [NUM_PAIRS-1:0]     join_w;
   logic [NUM_CH*DATA_W-1:0] per_flat, dty_flat, cnt_flat;

   pwm_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .cnt_flat(cnt_flat), .rdata(rdata), .en_o(en_w), .pol_o(pol_w),
      .join_o(join_w), .per_flat(per_flat), .dty_flat(dty_flat)
   );

   for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
      localparam int E = 2 * k;
      localparam int O = 2 * k + 1;
      pwm_pair #(.DATA_W(DATA_W)) u_pair (
         .clk(clk), .rst(rst), .join_req(join_w[k]),
         .en_e(en_w[E]), .en_o(en_w[O]), .pol_e(pol_w[E]), .pol_o(pol_w[O]),
         .tick_e(tick[E]), .tick_o(tick[O]),
         .per_e(per_flat[E*DATA_W +: DATA_W]), .per_o(per_flat[O*DATA_W +: DATA_W]),
         .dty_e(dty_flat[E*DATA_W +: DATA_W]), .dty_o(dty_flat[O*DATA_W +: DATA_W]),
         .cnt_e(cnt_flat[E*DATA_W +: DATA_W]), .cnt_o(cnt_flat[O*DATA_W +: DATA_W]),
         .out_e(pwm_out[E]), .out_o(pwm_out[O])
      );
   end
endmodule

// File: rtl/pairable_pwm_chk.sv
module pairable_pwm_chk #(
   parameter int NUM_CH = 8
) (
   input logic                clk,
   input logic                rst,
   input logic [NUM_CH-1:0]   tick,
   input logic                wr_en,
   input logic [NUM_CH-1:0]   en,
   input logic [NUM_CH/2-1:0] joined,
   input logic [NUM_CH-1:0]   pwm_out
);
   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      assert_disabled_low_R1: assert property (@(posedge clk) disable iff (rst)
         (!$past(en[n]) && !en[n]) |-> !pwm_out[n]);
      assert_enable_waits_R2: assert property (@(posedge clk) disable iff (rst)
         $rose(en[n]) |-> !pwm_out[n]);
   end

   for (genvar k = 0; k < NUM_CH / 2; k++) begin : g_pr
      assert_joined_even_low_R8: assert property (@(posedge clk) disable iff (rst)
         ($past(joined[k]) && joined[k]) |-> !pwm_out[2*k]);
   end

   assert_quiet_without_tick_R6: assert property (@(posedge clk) disable iff (rst)
      (!$past(wr_en) && !$past(wr_en, 2) && ($past(tick) == '0)) |-> $stable(pwm_out));
endmodule

bind pairable_pwm pairable_pwm_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
   .en(en_w), .joined(join_w), .pwm_out(pwm_out)
);

// File: tb/pairable_pwm_tb.sv
`timescale 1ns/1ps
module pairable_pwm_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] tick = '0;
   logic       wr_en = 1'b0;
   logic [4:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] pwm_out;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // bench model images
   logic [7:0] ren = '0, rpol = '0;
   int rper[8], rdty[8], mk[8], mper[8], mdty[8];
   bit mrun[8];

   always #2 clk = ~clk;

   pairable_pwm u_dut (
      .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; addr = 5'(a); wdata = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      if (a == 0) begin
         ren = 8'(d);
         for (int n = 0; n < 8; n++) if (!ren[n]) begin mrun[n] = 0; mk[n] = 0; end
      end
      if (a == 1) rpol = 8'(d);
      if (a >= 8 && a < 16) rper[a-8] = d;
      if (a >= 16 && a < 24) rdty[a-16] = d;
   endtask

   task automatic rd(input int a, output int v);
      addr = 5'(a);
      #1;
      v = int'(rdata);
   endtask

   task automatic pulse(input logic [7:0] m);
      @(negedge clk);
      tick = m;
      @(negedge clk);
      tick = '0;
   endtask

   task automatic tick_step(input logic [7:0] m);
      pulse(m);
      for (int n = 0; n < 8; n++) begin
         if (!ren[n]) begin
            mrun[n] = 0; mk[n] = 0;
         end else if (m[n]) begin
            if (!mrun[n] || (mk[n] + 1 >= mper[n])) begin
               mrun[n] = 1; mk[n] = 0; mper[n] = rper[n]; mdty[n] = rdty[n];
            end else begin
               mk[n]++;
            end
         end
      end
   endtask

   task automatic check_outs(input string tag);
      for (int n = 0; n < 8; n++) begin
         int e;
         string t;
         e = mrun[n] ? ((mk[n] < mdty[n]) ? int'(rpol[n]) : int'(!rpol[n])) : 0;
         if (tag != "") t = tag;
         else if (!mrun[n]) t = "R2";
         else if (mdty[n] >= mper[n] || mdty[n] == 0) t = "R5";
         else t = "R4";
         check(t, $sformatf("out[%0d]", n), int'(pwm_out[n]), e);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int v, k;
      for (int n = 0; n < 8; n++) begin
         rper[n] = 0; rdty[n] = 0; mk[n] = 0; mper[n] = 0; mdty[n] = 0; mrun[n] = 0;
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11: reset state of outputs and every address
      check("R11", "pwm_out after reset", int'(pwm_out), 0);
      for (int a = 0; a < 32; a++) begin
         rd(a, v);
         check("R11", $sformatf("rdata[%0d] after reset", a), v, 0);
      end

      // R3 R4 R5: sweep period 1..9, duty n on channel n, both polarities
      for (int pb = 0; pb < 2; pb++) begin
         for (int p = 1; p <= 9; p++) begin
            wr(0, 0);
            for (int n = 0; n < 8; n++) begin
               wr(8 + n, p);
               wr(16 + n, n);
            end
            wr(1, pb ? 8'h55 : 8'hAA);
            wr(0, 8'hFF);
            // R2: nothing before the first tick
            repeat (3) @(negedge clk);
            check("R2", "out before first tick", int'(pwm_out), 0);
            rd(24, v);
            check("R2", "count before first tick", v, 0);
            for (int t = 0; t < 2 * p + 2; t++) begin
               tick_step(8'hFF);
               check_outs("");
               rd(24, v);
               check("R3", "count ch0", v, mk[0]);
               rd(31, v);
               check("R3", "count ch7", v, mk[7]);
            end
         end
      end

      // R1: only the enabled channel runs; disable clears it
      wr(0, 0);
      for (int n = 0; n < 8; n++) begin
         wr(8 + n, 4);
         wr(16 + n, 2);
      end
      wr(1, 8'hFF);
      wr(0, 8'h20);
      for (int t = 0; t < 6; t++) begin
         tick_step(8'hFF);
         check_outs("R1");
      end
      rd(29, v);
      check("R1", "count ch5 running", v, mk[5]);
      wr(0, 0);
      check("R1", "out after disable", int'(pwm_out), 0);
      rd(29, v);
      check("R1", "count ch5 after disable", v, 0);

      // R6: period and duty rewrites wait for the next period start
      wr(8 + 3, 6);
      wr(16 + 3, 2);
      wr(0, 8'h08);
      for (int t = 0; t < 3; t++) begin
         tick_step(8'h08);
         check_outs("R6");
      end
      wr(8 + 3, 3);
      wr(16 + 3, 1);
      for (int t = 0; t < 12; t++) begin
         tick_step(8'h08);
         check_outs("R6");
      end
      wr(0, 0);

      // R7 R8: join pair 0 into period 0x0103, duty 0x0081, polarity 1
      wr(2, 8'h01);
      wr(8, 8'h01);
      wr(9, 8'h03);
      wr(16, 8'h00);
      wr(17, 8'h81);
      wr(1, 8'h02);
      wr(0, 8'h03);
      check("R2", "joined out before tick", int'(pwm_out[1:0]), 0);
      k = -1;
      for (int t = 0; t < 300; t++) begin
         pulse(8'h03);
         k = (k < 0) ? 0 : (k + 1) % 259;
         check("R8", "joined even out", int'(pwm_out[0]), 0);
         check("R7", "joined odd out", int'(pwm_out[1]), (k < 129) ? 1 : 0);
         if (k == 257) begin
            rd(24, v);
            check("R7", "joined high count byte", v, 1);
            rd(25, v);
            check("R7", "joined low count byte", v, 1);
         end
      end
      // R8: even tick and even enable have no effect while joined
      for (int t = 0; t < 5; t++) pulse(8'h01);
      rd(25, v);
      check("R8", "low count after even ticks", v, k % 256);
      rd(24, v);
      check("R8", "high count after even ticks", v, k / 256);
      check("R8", "odd out after even ticks", int'(pwm_out[1]), (k < 129) ? 1 : 0);

      // R9: leaving join mode stops and clears the pair
      wr(2, 0);
      check("R9", "pair out after unjoin", int'(pwm_out[1:0]), 0);
      rd(24, v);
      check("R9", "count ch0 after unjoin", v, 0);
      rd(25, v);
      check("R9", "count ch1 after unjoin", v, 0);
      pulse(8'h03);
      check("R9", "ch0 restarts (duty 0, pol 0)", int'(pwm_out[0]), 1);
      check("R9", "ch1 restarts (duty>=period, pol 1)", int'(pwm_out[1]), 1);

      // R10: unimplemented bits and addresses
      wr(2, 8'hF0);
      rd(2, v);
      check("R10", "join upper bits", v, 0);
      check("R10", "outs unchanged by upper join bits", int'(pwm_out[1:0]), 3);
      wr(3, 8'h5A);
      rd(3, v);
      check("R10", "unmapped address", v, 0);
      wr(2, 8'hFF);
      rd(2, v);
      check("R10", "join readback", v, 8'h0F);
      wr(2, 0);
      rd(1, v);
      check("R12", "polarity readback", v, 8'h02);
      rd(17, v);
      check("R12", "duty ch1 readback", v, 8'h81);

      // R11: reset while running
      wr(0, 8'hFF);
      tick_step(8'hFF);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R11", "out during reset", int'(pwm_out), 0);
      rst = 1'b0;
      @(negedge clk);
      rd(0, v);
      check("R11", "enable after reset", v, 0);
      rd(8, v);
      check("R11", "period ch0 after reset", v, 0);
      rd(25, v);
      check("R11", "count ch1 after reset", v, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule